// File: doc/BRIEF.md
# RTC Snapshot and Base-Time Load Control

This block sits between a set of free-running BCD timekeeping counters and the time registers that software sees. In normal operation the holding registers copy the counters on every clock, so a read returns the current time. Software can set a snapshot bit so that the holding registers stop following the counters while a multi-byte read is in progress. It can also set a load bit, which freezes the holding registers and opens them to bus writes. Clearing the load bit moves the written base time into the counters, but only if some time register was written in the meantime.

The counters keep running while either bit is held, so no seconds are lost. The block owns the two-digit BCD centuries counter. That counter advances when the year counter wraps on a one-second tick, and it reloads from the holding registers together with the external counters. The snapshot bit and the load bit act independently of each other.

Top module: `rtc_hold_ctrl`

## Requirements
- R1: After reset the control register reads 0, every holding register reads 0, the centuries counter is 0 and the load strobe is low.
- R2: With both control bits clear, each holding register takes its counter value on the next clock edge, and a bus read returns it.
- R3: While the snapshot bit (control bit 0) is 1, the holding registers keep their values as the counters change. Once the bit is cleared, the current counter values appear one clock later.
- R4: While the load bit (control bit 1) is 1, the holding registers ignore the counters and take bus writes to time addresses 0 to CNT_FIELDS. Address CNT_FIELDS is the centuries field.
- R5: A write to a time address while the load bit is 0 leaves the holding register unchanged.
- R6: Writing the control register with bit 1 cleared while it was 1, after at least one time write, raises the load strobe for exactly one cycle after that edge. During that cycle the load value equals the written holding contents, and the centuries counter takes the written centuries value.
- R7: Clearing the load bit with no time write since it was set produces no load strobe.
- R8: The centuries counter counts in BCD only when the tick and the year-wrap input are both high. Its low digit carries from 9 to 0 into the high digit, and 99 wraps to 00.
- R9: The two control bits are stored and read back independently at address CNT_FIELDS+1. The holding registers stay frozen while either bit is 1.
- R10: After a load strobe, the holding registers resume following the counters on the clock after the strobe cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | One-second tick |
| year_wrap_i | input | 1 | Year counter wraps from 99 to 00 on this tick |
| cnt_i | input | CNT_FIELDS*8 | Live BCD counter values, field 0 in the low byte |
| bus_we_i | input | 1 | Bus write strobe |
| bus_addr_i | input | ADDR_W | Bus address: time fields, then the control register |
| bus_wdata_i | input | 8 | Bus write data |
| bus_rdata_o | output | 8 | Bus read data for bus_addr_i |
| hold_o | output | (CNT_FIELDS+1)*8 | Holding registers, centuries in the top byte |
| century_o | output | 8 | Centuries counter, two BCD digits |
| load_stb_o | output | 1 | One-cycle counter load strobe |
| load_val_o | output | CNT_FIELDS*8 | Base time for the external counters |

## Verification
If the freeze state is wrong, a bus read shows it one clock after the counters change: a snapshot that drifts, or a frozen value that never updates. A wrong dirty flag shows up in the cycle after the load bit is cleared, as a missing or extra load strobe. A wrong strobe width shows up one cycle later. A centuries carry error is visible on century_o at the edge after the qualifying tick, and on a read of the centuries field one clock after that.

// File: rtl/rtc_hold_pkg.sv
package rtc_hold_pkg;
  localparam int FIELD_W    = 8;  // two BCD digits
  localparam int CTRL_R_BIT = 0;  // snapshot
  localparam int CTRL_W_BIT = 1;  // base-time load
  typedef logic [FIELD_W-1:0] field_t;
endpackage

// File: rtl/rtc_bcd_century.sv
module rtc_bcd_century
  import rtc_hold_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   inc_i,
  input  logic   load_i,
  input  field_t load_val_i,
  output field_t cent_o
);
  field_t cent_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cent_q <= '0;
    end else if (load_i) begin
      cent_q <= load_val_i;
    end else if (inc_i) begin
      if (cent_q[3:0] == 4'd9) begin
        cent_q[3:0] <= 4'd0;
        cent_q[7:4] <= (cent_q[7:4] == 4'd9) ? 4'd0 : cent_q[7:4] + 4'd1;
      end else begin
        cent_q[3:0] <= cent_q[3:0] + 4'd1;
      end
    end
  end

  assign cent_o = cent_q;

  a_r8_wrap_99: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(inc_i) && !$past(load_i) && $past(cent_q) == 8'h99) |-> cent_q == 8'h00);
  a_r6_cent_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(load_i) |-> cent_q == $past(load_val_i));
endmodule

// File: rtl/rtc_freeze_ctrl.sv
module rtc_freeze_ctrl
  import rtc_hold_pkg::*;
#(
  parameter int ADDR_W    = 3,
  parameter int CTRL_ADDR = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  field_t            bus_wdata_i,
  input  logic              time_wr_i,
  output logic              w_o,
  output logic              r_o,
  output logic              freeze_o,
  output logic              load_stb_o
);
  logic w_q, r_q, dirty_q, load_stb_q;
  logic ctrl_wr, w_release;

  assign ctrl_wr   = bus_we_i && (bus_addr_i == ADDR_W'(CTRL_ADDR));
  assign w_release = ctrl_wr && w_q && !bus_wdata_i[CTRL_W_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      w_q        <= 1'b0;
      r_q        <= 1'b0;
      dirty_q    <= 1'b0;
      load_stb_q <= 1'b0;
    end else begin
      if (ctrl_wr) begin
        w_q <= bus_wdata_i[CTRL_W_BIT];
        r_q <= bus_wdata_i[CTRL_R_BIT];
      end
      if (w_release)      dirty_q <= 1'b0;
      else if (time_wr_i) dirty_q <= 1'b1;
      load_stb_q <= w_release && dirty_q;
    end
  end

  assign w_o        = w_q;
  assign r_o        = r_q;
  // hold stays frozen through the strobe cycle so the load value is stable
  assign freeze_o   = w_q | r_q | load_stb_q;
  assign load_stb_o = load_stb_q;

  a_r6_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_stb_q |=> !load_stb_q);
  a_r7_needs_dirty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_stb_q |-> $past(dirty_q) && $past(w_q));
  a_r5_dirty_only_under_w: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dirty_q) |-> $past(w_q));
endmodule

// File: rtl/rtc_hold_regs.sv
module rtc_hold_regs
  import rtc_hold_pkg::*;
#(
  parameter int NF     = 7,
  parameter int ADDR_W = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               freeze_i,
  input  logic               wr_en_i,
  input  logic [ADDR_W-1:0]  wr_addr_i,
  input  field_t             wr_data_i,
  input  logic [NF*FIELD_W-1:0] live_i,
  output logic [NF*FIELD_W-1:0] hold_o
);
  logic [NF*FIELD_W-1:0] hold_q;

  for (genvar i = 0; i < NF; i++) begin : g_field
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        hold_q[i*FIELD_W +: FIELD_W] <= '0;
      end else if (wr_en_i && wr_addr_i == ADDR_W'(i)) begin
        hold_q[i*FIELD_W +: FIELD_W] <= wr_data_i;
      end else if (!freeze_i) begin
        hold_q[i*FIELD_W +: FIELD_W] <= live_i[i*FIELD_W +: FIELD_W];
      end
    end
  end

  assign hold_o = hold_q;

  a_r4_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(freeze_i) && !$past(wr_en_i)) |-> $stable(hold_q));
  a_r2_track: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(freeze_i) && !$past(wr_en_i)) |-> hold_q == $past(live_i));
endmodule

// File: rtl/rtc_hold_ctrl.sv
module rtc_hold_ctrl
  import rtc_hold_pkg::*;
#(
  parameter  int CNT_FIELDS = 6,
  localparam int NF         = CNT_FIELDS + 1,
  localparam int CTRL_ADDR  = NF,
  localparam int ADDR_W     = $clog2(NF + 1)
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          tick_i,
  input  logic                          year_wrap_i,
  input  logic [CNT_FIELDS*FIELD_W-1:0] cnt_i,
  input  logic                          bus_we_i,
  input  logic [ADDR_W-1:0]             bus_addr_i,
  input  logic [FIELD_W-1:0]            bus_wdata_i,
  output logic [FIELD_W-1:0]            bus_rdata_o,
  output logic [NF*FIELD_W-1:0]         hold_o,
  output logic [FIELD_W-1:0]            century_o,
  output logic                          load_stb_o,
  output logic [CNT_FIELDS*FIELD_W-1:0] load_val_o
);
  logic   w, r, freeze, load_stb, time_wr;
  field_t cent;
  logic [NF*FIELD_W-1:0] live, hold;

  assign time_wr = bus_we_i && w && (bus_addr_i < ADDR_W'(NF));
  assign live    = {cent, cnt_i};

  rtc_freeze_ctrl #(.ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR)) i_ctrl (
    .clk_i, .rst_ni, .bus_we_i, .bus_addr_i, .bus_wdata_i,
    .time_wr_i(time_wr), .w_o(w), .r_o(r), .freeze_o(freeze), .load_stb_o(load_stb)
  );

  rtc_hold_regs #(.NF(NF), .ADDR_W(ADDR_W)) i_hold (
    .clk_i, .rst_ni, .freeze_i(freeze), .wr_en_i(time_wr), .wr_addr_i(bus_addr_i),
    .wr_data_i(bus_wdata_i), .live_i(live), .hold_o(hold)
  );

  rtc_bcd_century i_cent (
    .clk_i, .rst_ni, .inc_i(tick_i && year_wrap_i), .load_i(load_stb),
    .load_val_i(hold[CNT_FIELDS*FIELD_W +: FIELD_W]), .cent_o(cent)
  );

  always_comb begin
    bus_rdata_o = '0;
    if (bus_addr_i == ADDR_W'(CTRL_ADDR)) begin
      bus_rdata_o[CTRL_W_BIT] = w;
      bus_rdata_o[CTRL_R_BIT] = r;
    end else begin
      for (int i = 0; i < NF; i++)
        if (bus_addr_i == ADDR_W'(i)) bus_rdata_o = hold[i*FIELD_W +: FIELD_W];
    end
  end

  assign hold_o     = hold;
  assign century_o  = cent;
  assign load_stb_o = load_stb;
  assign load_val_o = hold[CNT_FIELDS*FIELD_W-1:0];

  a_r10_load_matches_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_stb_o |-> $stable(load_val_o));
endmodule

// File: tb/test_rtc_hold_ctrl.sv
module test_rtc_hold_ctrl;
  localparam int CNT_FIELDS = 6;
  localparam int NF = CNT_FIELDS + 1;
  localparam int AW = $clog2(NF + 1);

  logic clk = 1'b0, rst_ni = 1'b0;
  logic tick_i = 1'b0, year_wrap_i = 1'b0;
  logic [CNT_FIELDS*8-1:0] cnt_i = '0;
  logic bus_we_i = 1'b0;
  logic [AW-1:0] bus_addr_i = '0;
  logic [7:0] bus_wdata_i = '0, bus_rdata_o, century_o;
  logic [NF*8-1:0] hold_o;
  logic load_stb_o;
  logic [CNT_FIELDS*8-1:0] load_val_o;

  int tests = 0, fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  rtc_hold_ctrl #(.CNT_FIELDS(CNT_FIELDS)) i_rtc_hold_ctrl (.clk_i(clk), .*);

  localparam logic [1:0] OP_CNT = 2'd0, OP_WR = 2'd1, OP_RD = 2'd2;
  typedef struct packed {
    logic [1:0] op;
    logic [2:0] addr;
    logic [7:0] data;
    logic [3:0] req;
  } vec_t;
  localparam int NV = 30;
  // RD: data is the expected read value
  localparam vec_t VEC [NV] = '{
    '{OP_RD, 3'd7, 8'h00, 4'd1},  // R1 control clear
    '{OP_RD, 3'd0, 8'h00, 4'd1},  // R1
    '{OP_CNT,3'd0, 8'h11, 4'd2},
    '{OP_RD, 3'd0, 8'h11, 4'd2},  // R2 tracking
    '{OP_RD, 3'd5, 8'h11, 4'd2},
    '{OP_RD, 3'd6, 8'h00, 4'd2},
    '{OP_WR, 3'd7, 8'h01, 4'd3},  // snapshot on
    '{OP_CNT,3'd0, 8'h22, 4'd3},
    '{OP_RD, 3'd0, 8'h11, 4'd3},  // R3 frozen
    '{OP_RD, 3'd7, 8'h01, 4'd9},  // R9 readback
    '{OP_WR, 3'd7, 8'h00, 4'd3},
    '{OP_CNT,3'd0, 8'h22, 4'd3},
    '{OP_RD, 3'd0, 8'h22, 4'd3},  // R3 resumed
    '{OP_WR, 3'd7, 8'h01, 4'd5},
    '{OP_WR, 3'd0, 8'h55, 4'd5},  // ignored, W=0
    '{OP_RD, 3'd0, 8'h22, 4'd5},  // R5
    '{OP_WR, 3'd7, 8'h00, 4'd5},
    '{OP_CNT,3'd0, 8'h44, 4'd2},
    '{OP_RD, 3'd0, 8'h44, 4'd2},
    '{OP_WR, 3'd7, 8'h02, 4'd4},  // load bit on
    '{OP_CNT,3'd0, 8'h66, 4'd4},
    '{OP_RD, 3'd0, 8'h44, 4'd4},  // R4 frozen
    '{OP_WR, 3'd0, 8'h12, 4'd4},
    '{OP_RD, 3'd0, 8'h12, 4'd4},  // R4 write lands
    '{OP_WR, 3'd6, 8'h19, 4'd4},
    '{OP_RD, 3'd6, 8'h19, 4'd4},
    '{OP_WR, 3'd7, 8'h03, 4'd9},
    '{OP_WR, 3'd7, 8'h02, 4'd9},  // R released, W still held
    '{OP_CNT,3'd0, 8'h77, 4'd9},
    '{OP_RD, 3'd1, 8'h44, 4'd9}   // R9 still frozen
  };

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic set_cnt(input logic [7:0] v);
    for (int i = 0; i < CNT_FIELDS; i++) cnt_i[i*8 +: 8] = v;
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
    bus_we_i = 1'b1; bus_addr_i = a; bus_wdata_i = d;
    @(negedge clk);
    bus_we_i = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, input logic [7:0] e, input string req);
    bus_addr_i = a;
    #1;
    check(bus_rdata_o === e, req, bus_rdata_o, e);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog act=hung exp=done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    check(load_stb_o === 1'b0, "R1 strobe", load_stb_o, 0);
    check(century_o === 8'h00, "R1 century", century_o, 0);

    foreach (VEC[k]) begin
      case (VEC[k].op)
        OP_CNT: begin set_cnt(VEC[k].data); @(negedge clk); end
        OP_WR:  wr(AW'(VEC[k].addr), VEC[k].data);
        default: begin
          bus_addr_i = AW'(VEC[k].addr);
          #1;
          check(bus_rdata_o === VEC[k].data, $sformatf("R%0d vec%0d", VEC[k].req, k),
                bus_rdata_o, VEC[k].data);
          @(negedge clk);
        end
      endcase
    end

    // R6: release W after writes
    wr(AW'(7), 8'h00);
    check(load_stb_o === 1'b1, "R6 strobe high", load_stb_o, 1);
    check(load_val_o[7:0] === 8'h12, "R6 load value f0", load_val_o[7:0], 8'h12);
    check(load_val_o[15:8] === 8'h44, "R6 load value f1", load_val_o[15:8], 8'h44);
    cnt_i = load_val_o;  // external counters load at the strobe edge
    @(negedge clk);
    check(load_stb_o === 1'b0, "R6 one-cycle pulse", load_stb_o, 0);
    check(century_o === 8'h19, "R6 century loaded", century_o, 8'h19);
    cnt_i[7:0] = 8'h13;
    @(negedge clk);
    @(negedge clk);
    rd(AW'(0), 8'h13, "R10 resume after load");
    rd(AW'(6), 8'h19, "R10 century field");

    // R7: release W without writes
    wr(AW'(7), 8'h02);
    wr(AW'(7), 8'h00);
    for (int i = 0; i < 3; i++) begin
      check(load_stb_o === 1'b0, "R7 no strobe", load_stb_o, 0);
      @(negedge clk);
    end

    // R8: century counting
    year_wrap_i = 1'b1; @(negedge clk); year_wrap_i = 1'b0;
    check(century_o === 8'h19, "R8 wrap without tick", century_o, 8'h19);
    tick_i = 1'b1; @(negedge clk); tick_i = 1'b0;
    check(century_o === 8'h19, "R8 tick without wrap", century_o, 8'h19);
    tick_i = 1'b1; year_wrap_i = 1'b1; @(negedge clk); tick_i = 1'b0; year_wrap_i = 1'b0;
    check(century_o === 8'h20, "R8 digit carry", century_o, 8'h20);
    @(negedge clk);
    rd(AW'(6), 8'h20, "R8 century read");
    tick_i = 1'b1; year_wrap_i = 1'b1; @(negedge clk); tick_i = 1'b0; year_wrap_i = 1'b0;
    check(century_o === 8'h21, "R8 low digit inc", century_o, 8'h21);
    wr(AW'(7), 8'h02);
    wr(AW'(6), 8'h99);
    wr(AW'(7), 8'h00);
    @(negedge clk);
    check(century_o === 8'h99, "R6 century 99 loaded", century_o, 8'h99);
    tick_i = 1'b1; year_wrap_i = 1'b1; @(negedge clk); tick_i = 1'b0; year_wrap_i = 1'b0;
    check(century_o === 8'h00, "R8 wrap 99 to 00", century_o, 8'h00);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule